// File: doc/BRIEF.md
# Five-Pin GPIO Port Register Block

This block holds the control and status registers of a five-pin general-purpose I/O port on a microcontroller peripheral bus. Software sets a direction mask and an output value. It reads back either its own output value or the live state of the pins. A pin whose direction bit is 1 drives the output value. A pin whose direction bit is 0 is left floating, and its external level is reported on a read.

The direction mask has two initialization rules. A power-on reset or a hardware standby loads it again. Its top pin then comes up driving in operating modes 1, 4 and 5, and as an input in every other mode. A manual reset and a software standby leave the mask untouched. While in software standby, an enable input decides whether the driven pins keep their state or float. All registers sit at fixed 16-bit addresses. A write takes a single strobe, and a read is combinational.

Top module: `gpio5_port_regs`

## Requirements
- R1: A write with `wr_en` high updates the addressed register on that rising clock edge. The direction register is at 0xFEBF, the output register at 0xFF6F, and only `wdata[4:0]` is stored.
- R2: A read of the direction address always returns 0xFF. Register bits 7 to 5 do not exist.
- R3: While `por_n` is low or `hw_stby` is high, direction bits 3..0 are cleared. Direction bit 4 is set to 1 if `mode` is 1, 4 or 5, and cleared for modes 0, 2, 3, 6 and 7. The output register is cleared.
- R4: While `mrst_n` is low, the output register is cleared and the direction register keeps its value.
- R5: In software standby both registers keep their values. Writes are ignored while any reset or standby input is active.
- R6: Outside standby, `pin_oe` equals the direction register and `pin_out` equals the output register.
- R7: With `hw_stby` high, `pin_oe` is all zeros. With `sw_stby` high, `pin_oe` is all zeros if `oe_stby` is 0 and equals the direction register if `oe_stby` is 1.
- R8: A read of 0xFF6F returns ones in bits 7..5 and the output register in bits 4..0.
- R9: A read of the pin-state address 0xFF5F returns ones in bits 7..5. Each bit i in 4..0 is the output register bit when direction bit i is 1, and `pin_in[i]` otherwise.
- R10: Writes to 0xFF5F change neither register.
- R11: A change of `mode` outside power-on reset and hardware standby leaves the direction register unchanged.
- R12: A read of any other address returns 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| mrst_n | input | 1 | Manual reset, active low, synchronous |
| hw_stby | input | 1 | Hardware standby indication |
| sw_stby | input | 1 | Software standby indication |
| oe_stby | input | 1 | Keep driving pins during software standby |
| mode | input | 3 | Operating mode |
| wr_en | input | 1 | Write strobe |
| addr | input | 16 | Lower 16 address bits |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pin_in | input | 5 | Sampled pin levels |
| pin_oe | output | 5 | Per-pin output enable |
| pin_out | output | 5 | Per-pin output value |

## Verification
The assertions assume that the reset and standby inputs are synchronous levels that are held for at least one full clock cycle. They also assume that `addr` and `wr_en` are stable around each rising edge. The bench changes every input only on falling edges, and it pulses each reset or standby input for a whole cycle, so the stimulus stays inside these assumptions. The bench sweeps all eight modes through both the power-on and the hardware-standby initialization. It also sweeps all 32 direction masks against varied output values and pin levels.

// File: rtl/gpio5_port_regs.sv
module gpio5_port_regs #(
  parameter int          NPIN     = 5,
  parameter logic [15:0] DIR_ADDR = 16'hFEBF,
  parameter logic [15:0] OUT_ADDR = 16'hFF6F,
  parameter logic [15:0] PIN_ADDR = 16'hFF5F
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            mrst_n,
  input  logic            hw_stby,
  input  logic            sw_stby,
  input  logic            oe_stby,
  input  logic [2:0]      mode,
  input  logic            wr_en,
  input  logic [15:0]     addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] pin_out
);
  localparam int PAD = 8 - NPIN;

  logic [NPIN-1:0] dir_q, dat_q, dir_init, pin_view;
  logic cold, boot_high, wr_ok, drive_ok, hit_dir, hit_out, hit_pin;

  assign cold      = !por_n || hw_stby;
  assign boot_high = (mode == 3'd1) || (mode == 3'd4) || (mode == 3'd5);
  assign dir_init  = {boot_high, {(NPIN-1){1'b0}}};
  assign wr_ok     = wr_en && !cold && mrst_n && !sw_stby;

  assign hit_dir = (addr == DIR_ADDR);
  assign hit_out = (addr == OUT_ADDR);
  assign hit_pin = (addr == PIN_ADDR);

  always_ff @(posedge clk) begin
    if (cold)                  dir_q <= dir_init;
    else if (wr_ok && hit_dir) dir_q <= wdata[NPIN-1:0];
  end

  always_ff @(posedge clk) begin
    if (cold || !mrst_n)       dat_q <= '0;
    else if (wr_ok && hit_out) dat_q <= wdata[NPIN-1:0];
  end

  assign drive_ok = !hw_stby && !(sw_stby && !oe_stby);
  assign pin_oe   = drive_ok ? dir_q : '0;
  assign pin_out  = dat_q;
  assign pin_view = (dir_q & dat_q) | (~dir_q & pin_in);

  always_comb begin
    if (hit_dir)      rdata = 8'hFF;
    else if (hit_out) rdata = {{PAD{1'b1}}, dat_q};
    else if (hit_pin) rdata = {{PAD{1'b1}}, pin_view};
    else              rdata = 8'h00;
  end
endmodule

module gpio5_port_regs_chk #(
  parameter int          NPIN     = 5,
  parameter logic [15:0] DIR_ADDR = 16'hFEBF,
  parameter logic [15:0] PIN_ADDR = 16'hFF5F
) (
  input logic            clk,
  input logic            por_n,
  input logic            mrst_n,
  input logic            hw_stby,
  input logic            sw_stby,
  input logic            oe_stby,
  input logic [2:0]      mode,
  input logic            wr_en,
  input logic [15:0]     addr,
  input logic [7:0]      rdata,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] dir,
  input logic [NPIN-1:0] data
);
  assert_cold_init_R3: assert property (@(posedge clk) disable iff (hw_stby)
    !por_n |=> (dir == {($past(mode) == 3'd1 || $past(mode) == 3'd4 || $past(mode) == 3'd5),
                        {(NPIN-1){1'b0}}}) && (data == '0));

  assert_mrst_keep_R4: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n && !hw_stby) |=> $stable(dir) && (data == '0));

  assert_sw_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
    (sw_stby && !hw_stby && mrst_n) |=> $stable(dir) && $stable(data));

  assert_hw_float_R7: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |-> (pin_oe == '0));

  assert_sw_float_R7: assert property (@(posedge clk) disable iff (!por_n)
    (sw_stby && !oe_stby) |-> (pin_oe == '0));

  assert_dir_read_R2: assert property (@(posedge clk) disable iff (!por_n)
    (addr == DIR_ADDR) |-> (rdata == 8'hFF));

  assert_pin_wr_R10: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == PIN_ADDR && !hw_stby && mrst_n) |=> $stable(dir) && $stable(data));
endmodule

bind gpio5_port_regs gpio5_port_regs_chk #(
  .NPIN(NPIN), .DIR_ADDR(DIR_ADDR), .PIN_ADDR(PIN_ADDR)
) u_chk (
  .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
  .oe_stby(oe_stby), .mode(mode), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .pin_oe(pin_oe), .dir(dir_q), .data(dat_q)
);

// File: tb/tb_gpio5_port_regs.sv
module tb_gpio5_port_regs;
  localparam logic [15:0] A_DIR = 16'hFEBF;
  localparam logic [15:0] A_OUT = 16'hFF6F;
  localparam logic [15:0] A_PIN = 16'hFF5F;

  logic clk = 0;
  logic por_n = 0, mrst_n = 1, hw_stby = 0, sw_stby = 0, oe_stby = 0, wr_en = 0;
  logic [2:0]  mode = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wdata = 0, rdata;
  logic [4:0]  pin_in = 0, pin_oe, pin_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio5_port_regs dut (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .oe_stby(oe_stby), .mode(mode), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  function automatic logic boot(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd4) || (m == 3'd5);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = 16'h0000;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_por(input logic [2:0] m);
    @(negedge clk); mode = m; por_n = 0;
    @(negedge clk); por_n = 1;
  endtask

  initial begin
    logic [7:0] r;
    repeat (2) @(negedge clk);
    por_n = 1;
    pin_in = 5'h15;
    rd(A_DIR, r); chk("R2 reset dir read", r, 8'hFF);
    rd(A_OUT, r); chk("R3 reset out read", r, 8'hE0);
    rd(A_PIN, r); chk("R9 reset pin read", r, 8'hF5);
    chk("R3 reset oe", {3'b0, pin_oe}, 8'h00);

    for (int m = 0; m < 8; m++) begin
      pulse_por(m[2:0]);
      #1 chk("R3 por mode oe", {3'b0, pin_oe}, {3'b0, boot(m[2:0]), 4'b0});
      wr(A_OUT, 8'h1F);
      pin_in = 5'h00;
      rd(A_PIN, r); chk("R9 por mode pin read", r, {3'b111, boot(m[2:0]), 4'b0});
      wr(A_DIR, 8'h0F);
      @(negedge clk); hw_stby = 1;
      #1 chk("R7 hw standby float", {3'b0, pin_oe}, 8'h00);
      @(negedge clk); hw_stby = 0;
      #1 chk("R3 hw standby init", {3'b0, pin_oe}, {3'b0, boot(m[2:0]), 4'b0});
      rd(A_OUT, r); chk("R3 hw standby clears out", r, 8'hE0);
    end

    pulse_por(3'd2);
    for (int d = 0; d < 32; d++) begin
      logic [4:0] dv, ov, pv;
      dv = d[4:0]; ov = 5'(d * 7); pv = 5'(d * 13 + 5);
      wr(A_DIR, {3'b101, dv});
      wr(A_OUT, {3'b010, ov});
      pin_in = pv;
      #1 chk("R1 R6 oe follows dir", {3'b0, pin_oe}, {3'b0, dv});
      chk("R6 pin_out follows out", {3'b0, pin_out}, {3'b0, ov});
      rd(A_OUT, r); chk("R8 out read", r, {3'b111, ov});
      rd(A_PIN, r); chk("R9 pin read", r, {3'b111, (dv & ov) | (~dv & pv)});
      rd(A_DIR, r); chk("R2 dir read", r, 8'hFF);
    end

    wr(A_DIR, 8'h0A); wr(A_OUT, 8'h1F);
    @(negedge clk); mrst_n = 0; addr = A_DIR; wdata = 8'h00; wr_en = 1;
    @(negedge clk); mrst_n = 1; wr_en = 0;
    #1 chk("R4 manual reset keeps dir", {3'b0, pin_oe}, 8'h0A);
    chk("R4 manual reset clears out", {3'b0, pin_out}, 8'h00);

    wr(A_DIR, 8'h13); wr(A_OUT, 8'h05);
    @(negedge clk); sw_stby = 1; oe_stby = 0; mode = 3'd1;
    #1 chk("R7 sw standby float", {3'b0, pin_oe}, 8'h00);
    wr(A_DIR, 8'h00); wr(A_OUT, 8'h1A);
    @(negedge clk); oe_stby = 1;
    #1 chk("R7 sw standby hold drive", {3'b0, pin_oe}, 8'h13);
    @(negedge clk); sw_stby = 0; oe_stby = 0;
    #1 chk("R5 sw standby keeps dir", {3'b0, pin_oe}, 8'h13);
    chk("R5 sw standby keeps out", {3'b0, pin_out}, 8'h05);

    pulse_por(3'd3);
    @(negedge clk); mode = 3'd4;
    repeat (3) @(negedge clk);
    #1 chk("R11 mode change ignored", {3'b0, pin_oe}, 8'h00);

    wr(A_DIR, 8'h06); wr(A_OUT, 8'h09);
    wr(A_PIN, 8'hFF);
    #1 chk("R10 pin write keeps dir", {3'b0, pin_oe}, 8'h06);
    chk("R10 pin write keeps out", {3'b0, pin_out}, 8'h09);

    wr(16'h1234, 8'h1F);
    #1 chk("R12 unmapped write dir", {3'b0, pin_oe}, 8'h06);
    chk("R12 unmapped write out", {3'b0, pin_out}, 8'h09);
    rd(16'h1234, r); chk("R12 unmapped read", r, 8'h00);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); errors++; checks++; $display("FAIL watchdog expired"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule